// File: doc/BRIEF.md
# Integer ALU with Signed Set-Compare

This block is the integer execution stage of a 32-bit load/store processor. Each cycle it can accept one operation: a 5-bit operation code and two 32-bit operands. One clock edge later it presents the 32-bit result, and it also presents a flag that marks signed arithmetic overflow. Operand selection happens upstream. When the instruction carries an immediate, the decode stage has already placed it on the second operand, and the ALU treats both cases the same way.

The operation set has the following groups:
- wrapping add and subtract, each in a signed and an unsigned form;
- the three bitwise logic operations;
- three shifts whose distance is taken from the second operand;
- an operation that moves a 16-bit immediate into the upper half-word;
- six condition tests that return the word 1 when the condition holds and the word 0 when it does not.

Internally, a decoder turns the operation code into a small bundle of strobes. A datapath computes every function unit in parallel and registers the selected one. The writeback stage consumes the registered result when the output valid flag is high.

Top module: `intAlu`

## Requirements
- R1: While reset is held, and after it is released with no operation issued, outValid, result and overflow are all 0.
- R2: An operation presented with inValid high at a rising edge appears on result and overflow after that edge, and outValid is high for exactly that one cycle. While inValid is low, result and overflow keep their values.
- R3: Code 0 (signed add) and code 1 (unsigned add) give opA+opB modulo 2^32. Code 2 (signed subtract) and code 3 (unsigned subtract) give opA-opB modulo 2^32.
- R4: overflow is 1 only for code 0 or code 2, and only when the true signed two's-complement sum or difference does not fit in 32 bits. Codes 1 and 3 and every other code give overflow 0.
- R5: Code 4 gives opA AND opB, code 5 gives opA OR opB, and code 6 gives opA XOR opB.
- R6: Code 7 shifts opA left with zero fill, code 8 shifts it right with zero fill, and code 9 shifts it right while copying the sign bit. The distance is opB[4:0], and opB[31:5] has no effect.
- R7: Code 10 gives {opB[15:0], 16'h0000}. opA and opB[31:16] have no effect.
- R8: Codes 11 to 16 compare opA with opB as signed two's-complement numbers. The tests are 11 less-than, 12 greater-than, 13 less-or-equal, 14 greater-or-equal, 15 equal and 16 not-equal. The result is 32'd1 when the test holds and 32'd0 when it does not.
- R9: Codes 17 to 31 give result 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (register or immediate) |
| outValid | output | 1 | Result registered from the previous cycle |
| result | output | 32 | Registered result word |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
Every result and every overflow flag is due one rising edge after the edge that captures inValid, and outValid marks that same cycle. The bench changes inputs on falling edges and holds inValid high for exactly one rising edge. It reads the outputs on the following falling edge, which lies half a period after the single register stage has updated. For the hold check, the bench lowers inValid and changes the operands, waits several edges, and then confirms that the last result and flag have not moved.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int OP_W = 5;

  // Operation codes. The numeric values are part of the block's interface.
  localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OP_W-1:0] OP_ADDU = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 5'd2;
  localparam logic [OP_W-1:0] OP_SUBU = 5'd3;
  localparam logic [OP_W-1:0] OP_AND  = 5'd4;
  localparam logic [OP_W-1:0] OP_OR   = 5'd5;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd6;
  localparam logic [OP_W-1:0] OP_SLL  = 5'd7;
  localparam logic [OP_W-1:0] OP_SRL  = 5'd8;
  localparam logic [OP_W-1:0] OP_SRA  = 5'd9;
  localparam logic [OP_W-1:0] OP_LHI  = 5'd10;
  localparam logic [OP_W-1:0] OP_SLT  = 5'd11;
  localparam logic [OP_W-1:0] OP_SGT  = 5'd12;
  localparam logic [OP_W-1:0] OP_SLE  = 5'd13;
  localparam logic [OP_W-1:0] OP_SGE  = 5'd14;
  localparam logic [OP_W-1:0] OP_SEQ  = 5'd15;
  localparam logic [OP_W-1:0] OP_SNE  = 5'd16;

  // Function unit that drives the result.
  typedef enum logic [2:0] {
    U_NONE, U_ADD, U_LOG, U_SHF, U_LHI, U_CMP
  } unit_e;

  // Selector inside a unit.
  localparam logic [2:0] F_AND = 3'd0, F_OR  = 3'd1, F_XOR = 3'd2;
  localparam logic [2:0] F_SLL = 3'd0, F_SRL = 3'd1, F_SRA = 3'd2;
  localparam logic [2:0] F_LT  = 3'd0, F_GT  = 3'd1, F_LE  = 3'd2,
                         F_GE  = 3'd3, F_EQ  = 3'd4, F_NE  = 3'd5;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    unit_e      unit;
    logic       sub;
    logic       ovfEn;
    logic [2:0] fn;
  } aluCtrl_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] op,
  output aluCtrl_t        ctl
);
  always_comb begin
    ctl = '{unit: U_NONE, sub: 1'b0, ovfEn: 1'b0, fn: 3'd0};
    case (op)
      OP_ADD:  begin ctl.unit = U_ADD; ctl.ovfEn = 1'b1; end
      OP_ADDU: begin ctl.unit = U_ADD; end
      OP_SUB:  begin ctl.unit = U_ADD; ctl.sub = 1'b1; ctl.ovfEn = 1'b1; end
      OP_SUBU: begin ctl.unit = U_ADD; ctl.sub = 1'b1; end
      OP_AND:  begin ctl.unit = U_LOG; ctl.fn = F_AND; end
      OP_OR:   begin ctl.unit = U_LOG; ctl.fn = F_OR;  end
      OP_XOR:  begin ctl.unit = U_LOG; ctl.fn = F_XOR; end
      OP_SLL:  begin ctl.unit = U_SHF; ctl.fn = F_SLL; end
      OP_SRL:  begin ctl.unit = U_SHF; ctl.fn = F_SRL; end
      OP_SRA:  begin ctl.unit = U_SHF; ctl.fn = F_SRA; end
      OP_LHI:  begin ctl.unit = U_LHI; end
      OP_SLT:  begin ctl.unit = U_CMP; ctl.fn = F_LT; end
      OP_SGT:  begin ctl.unit = U_CMP; ctl.fn = F_GT; end
      OP_SLE:  begin ctl.unit = U_CMP; ctl.fn = F_LE; end
      OP_SGE:  begin ctl.unit = U_CMP; ctl.fn = F_GE; end
      OP_SEQ:  begin ctl.unit = U_CMP; ctl.fn = F_EQ; end
      OP_SNE:  begin ctl.unit = U_CMP; ctl.fn = F_NE; end
      default: ; // unused codes select no unit (R9)
    endcase
  end

  // Overflow reporting is enabled only for the signed add and subtract.
  always_comb begin
    AST_OVF_ONLY_SIGNED: assert (!ctl.ovfEn || op == OP_ADD || op == OP_SUB); // R4
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  aluCtrl_t         ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);
  localparam int SH_W = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  // Adder: subtraction is addition of the inverted operand plus one.
  logic [WIDTH-1:0] bOp, sum;
  logic             ovfNext;
  always_comb begin
    bOp     = ctl.sub ? ~opB : opB;
    sum     = opA + bOp + {{(WIDTH-1){1'b0}}, ctl.sub};
    ovfNext = ctl.ovfEn && (ctl.unit == U_ADD) &&
              (opA[MSB] == bOp[MSB]) && (sum[MSB] != opA[MSB]);
  end

  // Bitwise logic.
  logic [WIDTH-1:0] logicRes;
  always_comb begin
    case (ctl.fn)
      F_AND:   logicRes = opA & opB;
      F_OR:    logicRes = opA | opB;
      default: logicRes = opA ^ opB;
    endcase
  end

  // Shifter: the distance comes from the low bits of the second operand.
  logic [SH_W-1:0]  shamt;
  logic [WIDTH-1:0] shiftRes;
  always_comb begin
    shamt = opB[SH_W-1:0];
    case (ctl.fn)
      F_SLL:   shiftRes = opA << shamt;
      F_SRL:   shiftRes = opA >> shamt;
      default: shiftRes = $unsigned($signed(opA) >>> shamt);
    endcase
  end

  // Upper-half immediate load.
  logic [WIDTH-1:0] lhiRes;
  assign lhiRes = {opB[HALF-1:0], {(WIDTH-HALF){1'b0}}};

  // Signed set-compare.
  logic isLt, isEq, cmpBit;
  logic [WIDTH-1:0] cmpRes;
  always_comb begin
    isLt = $signed(opA) < $signed(opB);
    isEq = (opA == opB);
    case (ctl.fn)
      F_LT:    cmpBit = isLt;
      F_GT:    cmpBit = !isLt && !isEq;
      F_LE:    cmpBit = isLt || isEq;
      F_GE:    cmpBit = !isLt;
      F_EQ:    cmpBit = isEq;
      default: cmpBit = !isEq;
    endcase
    cmpRes = {{(WIDTH-1){1'b0}}, cmpBit};
  end

  // Result multiplexer.
  logic [WIDTH-1:0] resNext;
  always_comb begin
    case (ctl.unit)
      U_ADD:   resNext = sum;
      U_LOG:   resNext = logicRes;
      U_SHF:   resNext = shiftRes;
      U_LHI:   resNext = lhiRes;
      U_CMP:   resNext = cmpRes;
      default: resNext = '0;
    endcase
  end

  // Single output register stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result   <= resNext;
        overflow <= ovfNext;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(overflow))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctl.ovfEn) |=> !overflow); // R4
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.unit == U_CMP) |=> (result[WIDTH-1:1] == '0)); // R8
  AST_LHI_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.unit == U_LHI) |=> (result[HALF-1:0] == '0)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.unit == U_NONE) |=> (result == '0 && !overflow)); // R9
endmodule

// File: rtl/intAlu.sv
module intAlu
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             overflow
);
  aluCtrl_t ctl;

  aluCtrl u_ctrl (
    .op  (op),
    .ctl (ctl)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .result   (result),
    .overflow (overflow)
  );
endmodule

// File: tb/intAlu_tb.sv
module intAlu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        outValid;
  logic [31:0] result;
  logic        overflow;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  intAlu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
    .opA(opA), .opB(opB), .outValid(outValid),
    .result(result), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent reference from the requirements.
  function automatic logic [32:0] model(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    logic [31:0] r = 32'd0;
    logic v = 1'b0;
    case (c)
      0: begin t = sa + sb; r = a + b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      1: r = a + b;
      2: begin t = sa - sb; r = a - b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      3: r = a - b;
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = a << b[4:0];
      8: r = a >> b[4:0];
      9: r = 32'(sa >>> b[4:0]);
      10: r = {b[15:0], 16'h0};
      11: r = {31'd0, sa < sb};
      12: r = {31'd0, sa > sb};
      13: r = {31'd0, sa <= sb};
      14: r = {31'd0, sa >= sb};
      15: r = {31'd0, sa == sb};
      16: r = {31'd0, sa != sb};
      default: r = 32'd0;
    endcase
    return {v, r};
  endfunction

  // Issue one operation and check the registered outputs one edge later.
  task automatic runOp(input string tag, input logic [4:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] e;
    @(negedge clk);
    op = c; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    e = model(c, a, b);
    chk({tag, " result"}, result, e[31:0]);
    chk({tag, " overflow"}, {31'd0, overflow}, {31'd0, e[32]});
    chk("R2 outValid", {31'd0, outValid}, 32'd1);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R1 result in reset", result, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outValid idle", {31'd0, outValid}, 32'd0);
    chk("R1 result idle", result, 32'd0);
    chk("R1 overflow idle", {31'd0, overflow}, 32'd0);
  endtask

  task automatic tAddSub();
    runOp("R3 add", 5'd0, 32'd100, 32'd23);
    runOp("R3 addu wrap", 5'd1, 32'hFFFF_FFFF, 32'd2);
    runOp("R3 sub", 5'd2, 32'd5, 32'd9);
    runOp("R3 subu", 5'd3, 32'd0, 32'd1);
    runOp("R3 add neg", 5'd0, 32'hFFFF_FFF0, 32'd4);
  endtask

  task automatic tOverflow();
    runOp("R4 add pos ovf", 5'd0, 32'h7FFF_FFFF, 32'd1);
    runOp("R4 add neg ovf", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF);
    runOp("R4 sub ovf", 5'd2, 32'h8000_0000, 32'd1);
    runOp("R4 sub pos ovf", 5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    runOp("R4 sub no ovf", 5'd2, 32'hFFFF_FFFF, 32'h8000_0000);
    runOp("R4 addu quiet", 5'd1, 32'h7FFF_FFFF, 32'd1);
    runOp("R4 subu quiet", 5'd3, 32'h8000_0000, 32'd1);
    runOp("R4 xor quiet", 5'd6, 32'h7FFF_FFFF, 32'd1);
  endtask

  task automatic tLogic();
    runOp("R5 and", 5'd4, 32'hF0F0_1234, 32'h0FF0_FF00);
    runOp("R5 or",  5'd5, 32'hF0F0_1234, 32'h0FF0_FF00);
    runOp("R5 xor", 5'd6, 32'hF0F0_1234, 32'h0FF0_FF00);
  endtask

  task automatic tShift();
    runOp("R6 sll", 5'd7, 32'h8000_0001, 32'd4);
    runOp("R6 srl", 5'd8, 32'h8000_0000, 32'd31);
    runOp("R6 sra", 5'd9, 32'h8000_0000, 32'd31);
    runOp("R6 sra pos", 5'd9, 32'h4000_0000, 32'd3);
    runOp("R6 upper amount ignored", 5'd7, 32'h0000_0003, 32'hFFFF_FFE1);
    runOp("R6 zero shift", 5'd8, 32'hDEAD_BEEF, 32'h0000_0020);
  endtask

  task automatic tLhi();
    runOp("R7 lhi", 5'd10, 32'hFFFF_FFFF, 32'hABCD_1234);
    runOp("R7 lhi zero", 5'd10, 32'h1234_5678, 32'hFFFF_0000);
  endtask

  task automatic tCompare();
    for (int c = 11; c <= 16; c++) begin
      runOp("R8 cmp neg<pos", 5'(c), 32'hFFFF_FFFF, 32'd1);
      runOp("R8 cmp equal", 5'(c), 32'h8000_0000, 32'h8000_0000);
      runOp("R8 cmp pos>neg", 5'(c), 32'd7, 32'h8000_0000);
    end
  endtask

  task automatic tUnused();
    runOp("R9 code 17", 5'd17, 32'h7FFF_FFFF, 32'd1);
    runOp("R9 code 31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic tHold();
    runOp("R2 setup", 5'd0, 32'h7FFF_FFFF, 32'd5);
    @(negedge clk);
    op = 5'd4; opA = 32'd0; opB = 32'd0;
    repeat (3) @(negedge clk);
    chk("R2 hold result", result, 32'h8000_0004);
    chk("R2 hold overflow", {31'd0, overflow}, 32'd1);
    chk("R2 outValid low", {31'd0, outValid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tReset();
    tAddSub();
    tOverflow();
    tLogic();
    tShift();
    tLhi();
    tCompare();
    tUnused();
    tHold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule